// File: doc/BRIEF.md
# Core Shutdown Sequencer

This block takes a DSP core subsystem from running to fully powered down in a fixed, safe order, triggered by a single stop command. It first asks an external bus-halt controller to quiesce the core's bus port. Once that controller reports completion, the block gates the core clock and applies the IO and word-line clamps. It then drops L2 standby and sleep retention. Next it switches off the memory banks one by one, engages the memory clamp, and removes power from the head switch. Finally it waits for the head switch to confirm that its reset has completed, and only then places the subsystem and the core in reset.

Delays are derived from one parameter, the clock cycles per microsecond, together with the microseconds per millisecond. Each millisecond wait is therefore an exact cycle count. If the head-switch acknowledge never falls within the poll budget, the block stops and raises a timeout error instead of asserting the resets. The error is held until the next stop command, which reruns the sequence. Every control output is a register. All inputs are synchronous to `clk`.

Top module: `core_shutdown_seq`

## Requirements
- R1: After synchronous reset the block is idle and running. halt_req=0, core_clk_en=1, io_clamp=0, wl_clamp=0, l2_stby_n=1, slp_ret_n=1, every bank_pwr bit is 1, mem_clamp=0, hs_on=1, subsys_rst=0, core_rst=0, seq_done=0 and timeout_err=0.
- R2: A stop_req sampled while idle, or after a timeout, raises halt_req on the next cycle. halt_req then holds, and no other control output changes, until halt_done is sampled high.
- R3: In the cycle after halt_done is sampled, halt_req falls and core_clk_en falls together. Then io_clamp rises, wl_clamp rises, l2_stby_n falls and slp_ret_n falls, one step per cycle in that order.
- R4: bank_pwr bits are cleared one at a time in ascending order, bit 0 first. Bit 0 clears one cycle after slp_ret_n falls. Each following bit clears exactly MS = CYC_PER_US*US_PER_MS cycles after the previous one.
- R5: mem_clamp rises exactly MS cycles after the last bank bit clears, and hs_on falls one cycle later.
- R6: hs_rst_ack is first sampled in the cycle CYC_PER_US-1 cycles after hs_on falls. After that it is sampled every MS cycles.
- R7: When a sample finds hs_rst_ack low, subsys_rst rises in the next cycle. core_rst and seq_done rise together one cycle after subsys_rst.
- R8: If the POLL_LIMIT-th sample still finds hs_rst_ack high, timeout_err rises in the next cycle. Neither reset output is asserted.
- R9: timeout_err stays high until a new stop_req, which clears it on the next cycle and runs the sequence again.
- R10: A stop_req while a sequence is running, or after seq_done, has no effect. seq_done and both resets hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Single-cycle shutdown command |
| halt_done | input | 1 | Bus-halt controller reports the port is halted |
| hs_rst_ack | input | 1 | Head-switch reset acknowledge, low when complete |
| halt_req | output | 1 | Halt command to the bus-halt controller |
| core_clk_en | output | 1 | Core clock gate enable |
| io_clamp | output | 1 | IO clamp |
| wl_clamp | output | 1 | Word-line clamp |
| l2_stby_n | output | 1 | L2 standby control, active low |
| slp_ret_n | output | 1 | Sleep retention control, active low |
| bank_pwr | output | NUM_BANKS | Per-bank memory power, 1 = on |
| mem_clamp | output | 1 | Compiler-memory clamp |
| hs_on | output | 1 | Head switch enable |
| subsys_rst | output | 1 | Subsystem reset |
| core_rst | output | 1 | Core reset |
| seq_done | output | 1 | Shutdown completed |
| timeout_err | output | 1 | Head-switch acknowledge timed out |

## Verification
The bench predicts the cycle of every output change and compares each observed change against that prediction, so a single-cycle slip is caught. One targeted case drives the acknowledge low exactly in its sampling cycle; a design that samples one cycle early or late misses it and reports a reset one poll late. A timeout run checks that neither reset ever rises and that the error holds. The run after that timeout has mostly unchanged outputs, so a design that failed to clear the error, or that re-powered any bank, shows up as an unexpected change. A stop_req pulsed in the middle of the bank walk and again after completion exposes a sequencer that restarts or resets its counters.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HALT,
    ST_IOCLAMP,
    ST_WLCLAMP,
    ST_STBY,
    ST_RETN,
    ST_BANK0,
    ST_BANKWAIT,
    ST_HSOFF,
    ST_POLL,
    ST_CORERST,
    ST_DONE,
    ST_FAIL
  } cpd_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cpd_delay.sv
// Down-counting delay: loading N makes expired rise N cycles later.
module cpd_delay #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/cpd_bank_mask.sv
// Per-bank power register, all on after reset, cleared one bank per request.
module cpd_bank_mask #(
  parameter int unsigned NB = 20,
  parameter int unsigned IW = cpd_pkg::idx_width(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [NB-1:0] pwr
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        pwr[b] <= 1'b1;
      end else if (clr_en && (clr_idx == IW'(b))) begin
        pwr[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/core_shutdown_seq.sv
module core_shutdown_seq #(
  parameter int unsigned CYC_PER_US = 125,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned NUM_BANKS  = 20,
  parameter int unsigned POLL_LIMIT = 200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_req,
  input  logic                 halt_done,
  input  logic                 hs_rst_ack,
  output logic                 halt_req,
  output logic                 core_clk_en,
  output logic                 io_clamp,
  output logic                 wl_clamp,
  output logic                 l2_stby_n,
  output logic                 slp_ret_n,
  output logic [NUM_BANKS-1:0] bank_pwr,
  output logic                 mem_clamp,
  output logic                 hs_on,
  output logic                 subsys_rst,
  output logic                 core_rst,
  output logic                 seq_done,
  output logic                 timeout_err
);
  import cpd_pkg::*;

  localparam int unsigned MS_CYC = CYC_PER_US * US_PER_MS;
  localparam int unsigned TW     = $clog2(MS_CYC + 1);
  localparam int unsigned IW     = idx_width(NUM_BANKS);
  localparam int unsigned PW     = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] MS_LOAD   = TW'(MS_CYC - 1);
  localparam logic [TW-1:0] US_LOAD   = TW'(CYC_PER_US - 1);
  localparam logic [IW-1:0] LAST_BANK = IW'(NUM_BANKS - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

  cpd_state_e    state;
  logic [IW-1:0] bank_idx;
  logic [PW-1:0] poll_cnt;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;
  logic          clr_en;
  logic [IW-1:0] clr_idx;

  cpd_delay #(.W(TW)) delay_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  cpd_bank_mask #(.NB(NUM_BANKS), .IW(IW)) banks_i (
    .clk     (clk),
    .rst     (rst),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .pwr     (bank_pwr)
  );

  // Timer reloads and bank clears happen in the cycle a wait ends,
  // so consecutive steps land exactly one wait apart.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = MS_LOAD;
    clr_en   = 1'b0;
    clr_idx  = bank_idx;
    case (state)
      ST_BANK0: begin
        tmr_load = 1'b1;
        clr_en   = 1'b1;
        clr_idx  = '0;
      end
      ST_BANKWAIT: begin
        if (tmr_exp && (bank_idx != LAST_BANK)) begin
          tmr_load = 1'b1;
          clr_en   = 1'b1;
          clr_idx  = bank_idx + 1'b1;
        end
      end
      ST_HSOFF: begin
        tmr_load = 1'b1;
        tmr_val  = US_LOAD;
      end
      ST_POLL: begin
        if (tmr_exp && hs_rst_ack && (poll_cnt != LAST_POLL)) begin
          tmr_load = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bank_idx    <= '0;
      poll_cnt    <= '0;
      halt_req    <= 1'b0;
      core_clk_en <= 1'b1;
      io_clamp    <= 1'b0;
      wl_clamp    <= 1'b0;
      l2_stby_n   <= 1'b1;
      slp_ret_n   <= 1'b1;
      mem_clamp   <= 1'b0;
      hs_on       <= 1'b1;
      subsys_rst  <= 1'b0;
      core_rst    <= 1'b0;
      seq_done    <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_FAIL: begin
          if (stop_req) begin
            timeout_err <= 1'b0;
            halt_req    <= 1'b1;
            state       <= ST_HALT;
          end
        end
        ST_HALT: begin
          if (halt_done) begin
            halt_req    <= 1'b0;
            core_clk_en <= 1'b0;
            state       <= ST_IOCLAMP;
          end
        end
        ST_IOCLAMP: begin
          io_clamp <= 1'b1;
          state    <= ST_WLCLAMP;
        end
        ST_WLCLAMP: begin
          wl_clamp <= 1'b1;
          state    <= ST_STBY;
        end
        ST_STBY: begin
          l2_stby_n <= 1'b0;
          state     <= ST_RETN;
        end
        ST_RETN: begin
          slp_ret_n <= 1'b0;
          bank_idx  <= '0;
          state     <= ST_BANK0;
        end
        ST_BANK0: begin
          state <= ST_BANKWAIT;
        end
        ST_BANKWAIT: begin
          if (tmr_exp) begin
            if (bank_idx == LAST_BANK) begin
              mem_clamp <= 1'b1;
              state     <= ST_HSOFF;
            end else begin
              bank_idx <= bank_idx + 1'b1;
            end
          end
        end
        ST_HSOFF: begin
          hs_on    <= 1'b0;
          poll_cnt <= '0;
          state    <= ST_POLL;
        end
        ST_POLL: begin
          if (tmr_exp) begin
            if (!hs_rst_ack) begin
              subsys_rst <= 1'b1;
              state      <= ST_CORERST;
            end else if (poll_cnt == LAST_POLL) begin
              timeout_err <= 1'b1;
              state       <= ST_FAIL;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        end
        ST_CORERST: begin
          core_rst <= 1'b1;
          seq_done <= 1'b1;
          state    <= ST_DONE;
        end
        ST_DONE: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/core_shutdown_seq_chk.sv
module core_shutdown_seq_chk #(
  parameter int unsigned NUM_BANKS = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 halt_done,
  input logic                 halt_req,
  input logic                 core_clk_en,
  input logic                 io_clamp,
  input logic                 wl_clamp,
  input logic [NUM_BANKS-1:0] bank_pwr,
  input logic                 mem_clamp,
  input logic                 hs_on,
  input logic                 subsys_rst,
  input logic                 core_rst,
  input logic                 seq_done,
  input logic                 timeout_err
);

  a_r2_halt_held: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !halt_done) |=> halt_req);

  a_r3_wl_after_io: assert property (@(posedge clk) disable iff (rst)
    $rose(wl_clamp) |-> (io_clamp && !core_clk_en));

  a_r4_one_bank_step: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_pwr ^ $past(bank_pwr)) <= 1);

  a_r4_bank_stays_off: assert property (@(posedge clk) disable iff (rst)
    (bank_pwr & ~$past(bank_pwr)) == '0);

  a_r5_hs_off_last: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_on) |-> (mem_clamp && (bank_pwr == '0)));

  a_r7_core_after_sub: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> $past(subsys_rst));

  a_r8_err_no_reset: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!subsys_rst && !core_rst));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> seq_done);

endmodule

bind core_shutdown_seq core_shutdown_seq_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .halt_done   (halt_done),
  .halt_req    (halt_req),
  .core_clk_en (core_clk_en),
  .io_clamp    (io_clamp),
  .wl_clamp    (wl_clamp),
  .bank_pwr    (bank_pwr),
  .mem_clamp   (mem_clamp),
  .hs_on       (hs_on),
  .subsys_rst  (subsys_rst),
  .core_rst    (core_rst),
  .seq_done    (seq_done),
  .timeout_err (timeout_err)
);

// File: tb/core_shutdown_seq_tb_top.sv
`timescale 1ns/1ps
module core_shutdown_seq_tb_top;

  localparam int US = 2;
  localparam int UPM = 4;
  localparam int MS = US * UPM;
  localparam int NB = 20;
  localparam int PL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0;
  logic halt_done = 1'b0;
  logic hs_rst_ack = 1'b1;
  logic halt_req, core_clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n;
  logic [NB-1:0] bank_pwr;
  logic mem_clamp, hs_on, subsys_rst, core_rst, seq_done, timeout_err;

  always #4 clk = ~clk;

  core_shutdown_seq #(
    .CYC_PER_US(US), .US_PER_MS(UPM), .NUM_BANKS(NB), .POLL_LIMIT(PL)
  ) dut_i (
    .clk(clk), .rst(rst), .stop_req(stop_req), .halt_done(halt_done),
    .hs_rst_ack(hs_rst_ack), .halt_req(halt_req), .core_clk_en(core_clk_en),
    .io_clamp(io_clamp), .wl_clamp(wl_clamp), .l2_stby_n(l2_stby_n),
    .slp_ret_n(slp_ret_n), .bank_pwr(bank_pwr), .mem_clamp(mem_clamp),
    .hs_on(hs_on), .subsys_rst(subsys_rst), .core_rst(core_rst),
    .seq_done(seq_done), .timeout_err(timeout_err)
  );

  int cyc = 0;
  int n_vec = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model of expected outputs
  logic m_halt, m_clk, m_io, m_wl, m_l2n, m_slp, m_mcl, m_hs, m_sub, m_core, m_done, m_err;
  logic [NB-1:0] m_bank;
  logic [31:0] m_last;

  int          q_cyc[$];
  logic [31:0] q_vec[$];
  string       q_req[$];

  wire [31:0] dut_vec = {halt_req, core_clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n,
                         mem_clamp, hs_on, subsys_rst, core_rst, seq_done, timeout_err, bank_pwr};

  function automatic logic [31:0] mvec();
    return {m_halt, m_clk, m_io, m_wl, m_l2n, m_slp, m_mcl, m_hs, m_sub, m_core, m_done, m_err, m_bank};
  endfunction

  task automatic model_reset();
    m_halt = 0; m_clk = 1; m_io = 0; m_wl = 0; m_l2n = 1; m_slp = 1;
    m_mcl = 0; m_hs = 1; m_sub = 0; m_core = 0; m_done = 0; m_err = 0;
    m_bank = '1;
    m_last = mvec();
  endtask

  task automatic push(input int c, input string r);
    if (mvec() != m_last) begin
      q_cyc.push_back(c);
      q_vec.push_back(mvec());
      q_req.push_back(r);
      m_last = mvec();
    end
  endtask

  // monitor: every output change is compared with the next expected item
  logic [31:0] prev_vec;
  always @(negedge clk) begin
    if (rst) begin
      prev_vec = dut_vec;
    end else if (dut_vec !== prev_vec) begin
      n_vec++;
      if (q_cyc.size() == 0) begin
        n_fail++;
        $display("FAIL R9/R10 unexpected change at cycle %0d: actual=%h expected=%h",
                 cyc, dut_vec, prev_vec);
      end else begin
        int c; logic [31:0] v; string r;
        c = q_cyc.pop_front(); v = q_vec.pop_front(); r = q_req.pop_front();
        if (c != cyc || v !== dut_vec) begin
          n_fail++;
          $display("FAIL %s: actual=%h at cycle %0d expected=%h at cycle %0d",
                   r, dut_vec, cyc, v, c);
        end
      end
      prev_vec = dut_vec;
    end
  end

  task automatic check_now(input string r);
    n_vec++;
    if (dut_vec !== mvec()) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", r, dut_vec, mvec());
    end
  endtask

  task automatic check_drained(input string r);
    n_vec++;
    if (q_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing change: actual=%h expected=%h at cycle %0d",
               r, dut_vec, q_vec[0], q_cyc[0]);
      q_cyc.delete(); q_vec.delete(); q_req.delete();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; stop_req = 0; halt_done = 0; hs_rst_ack = 1;
    q_cyc.delete(); q_vec.delete(); q_req.delete();
    repeat (5) @(negedge clk);
    model_reset();
    rst = 1'b0;
    @(negedge clk);
    check_now("R1");
  endtask

  // hdly: cycles from stop to halt_done; ackpoll: poll that sees ack low (0 = never)
  task automatic run_seq(input int hdly, input int ackpoll, input bit poke);
    int s, h, t, pk;
    string first;
    @(negedge clk);
    hs_rst_ack = 1'b1;
    s = cyc;
    h = s + hdly;
    first = m_err ? "R9" : "R2";
    m_halt = 1; m_err = 0; push(s + 1, first);
    m_halt = 0; m_clk = 0; push(h + 1, "R3");
    m_io = 1;  push(h + 2, "R3");
    m_wl = 1;  push(h + 3, "R3");
    m_l2n = 0; push(h + 4, "R3");
    m_slp = 0; push(h + 5, "R3");
    for (int k = 0; k < NB; k++) begin
      m_bank[k] = 1'b0;
      push(h + 6 + k * MS, "R4");
    end
    m_mcl = 1; push(h + 6 + NB * MS, "R5");
    m_hs = 0;  push(h + 7 + NB * MS, "R5");
    t = h + 7 + NB * MS;
    if (ackpoll > 0) begin
      pk = t + US + (ackpoll - 1) * MS;
      m_sub = 1; push(pk, "R6/R7");
      m_core = 1; m_done = 1; push(pk + 1, "R7");
    end else begin
      pk = t + US + (PL - 1) * MS;
      m_err = 1; push(pk, "R8");
    end
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    while (cyc < h) @(negedge clk);
    halt_done = 1'b1;
    @(negedge clk);
    halt_done = 1'b0;
    if (poke) begin
      // R10: command in the middle of the bank walk
      while (cyc < h + 10) @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
    end
    if (ackpoll > 0) begin
      while (cyc < pk - 1) @(negedge clk);
      hs_rst_ack = 1'b0;
    end
    while (cyc < pk + 4) @(negedge clk);
    check_drained(ackpoll > 0 ? "R7" : "R8");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // nominal run, ack already low at first poll
    run_seq(3, 1, 1'b0);
    // R10: stop after completion has no effect
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (20) @(negedge clk);
    check_now("R10");

    do_reset();
    // immediate halt_done, ack falls at poll 4, stop pulsed mid-sequence
    run_seq(1, 4, 1'b1);

    do_reset();
    // ack never falls: timeout
    run_seq(2, 0, 1'b0);
    repeat (40) @(negedge clk);
    check_now("R9");
    // rerun after timeout clears the error and completes
    run_seq(5, 2, 1'b0);
    check_now("R7");

    summary();
    $finish;
  end

endmodule